// File: doc/BRIEF.md
# Completion Interrupt Coalescing Counter

This block sits beside one instruction queue and decides when the queue's completion interrupt is raised. Each completed instruction that asked for a notification adds one to a pending-results count. Software reads the count, handles the results, and then writes an acknowledge value that is subtracted from the count. Software can also load the count directly, although this is meant for diagnostics.

An interrupt request is raised once enough results are pending or once they have waited long enough. The wait is measured by a hold-off timer. The timer advances on a free-running tick input, and its limit is a programmed time value scaled by 2^TSCALE_LOG2 (1024 by default). The timer stays at zero while nothing is pending. It restarts on every acknowledge or direct load. The count threshold is checked again straight after an acknowledge, so any results still above the threshold raise the interrupt again at once.

A write-1-to-set enable gates only the request line. Counting and timing carry on while the enable is clear.

Top module: `cmpl_irq_coalesce`

## Requirements
- R1: A cycle with `cmpl_vld` high and `cmpl_notify` high adds one to `cnt_rd` on the next clock edge. A completion with `cmpl_notify` low, or with `cmpl_vld` low, leaves the count unchanged.
- R2: `ack_we` subtracts `ack_val` from the count. The result is clamped at zero, never wrapping below zero. A notifying completion in the same cycle is combined with the acknowledge as one net change.
- R3: `cnt_we` loads `cnt_val` into the count. This load wins over a completion or an acknowledge in the same cycle. It also restarts the hold-off timer.
- R4: While the count is zero, the hold-off timer is held at zero and `irq` is low. The timer therefore starts from zero when the first result arrives.
- R5: While the count is nonzero, the timer advances by one on each clock edge that has `tick` high. It saturates at all-ones, so a time condition that has been reached stays reached.
- R6: If the programmed time value is nonzero, the time condition holds when the timer is at least that value times 2^TSCALE_LOG2. A time value of zero disables the time condition.
- R7: The count condition holds when the count is at least the programmed number value. A number value of zero acts as one.
- R8: Each acknowledge restarts the timer from zero. The count condition is evaluated again on the edge after the acknowledge, so `irq` may be high in the very next cycle.
- R9: The enable is set only by `ena_we` with `ena_bit`=1. A write with `ena_bit`=0 has no effect. While the enable is clear, `irq` is low but counting and timing continue.
- R10: An increment at the all-ones count leaves the count at all-ones.
- R11: After reset, the count, the timer, both programmed wait values and the enable are zero, and `irq` is low.
- R12: `irq` is a level. It is high exactly while the enable is set, the count is nonzero, and the time or count condition holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Free-running timer advance strobe |
| cmpl_vld | input | 1 | An instruction completed this cycle |
| cmpl_notify | input | 1 | The completing instruction requested a done notification |
| ack_we | input | 1 | Acknowledge write strobe |
| ack_val | input | CNT_W | Number of results acknowledged |
| cnt_we | input | 1 | Direct count write strobe |
| cnt_val | input | CNT_W | Value loaded by a direct count write |
| twait_we | input | 1 | Time hold-off write strobe |
| twait_val | input | TWAIT_W | Time hold-off in units of 2^TSCALE_LOG2 ticks |
| nwait_we | input | 1 | Number hold-off write strobe |
| nwait_val | input | NWAIT_W | Pending-result threshold |
| ena_we | input | 1 | Write-1-to-set enable strobe |
| ena_bit | input | 1 | Data bit of the enable write |
| cnt_rd | output | CNT_W | Current pending-result count |
| irq | output | 1 | Interrupt request level |

## Verification
The bench builds the block with a 6-bit count, a 6-bit number threshold, a 4-bit time value and a scale of 4. These small widths bring several corners within a few hundred cycles: count saturation at 63, timer saturation at 63 just above the largest time threshold of 60, and time-triggered interrupts. A behavioural model predicts the count and the request line on every cycle. The stimulus covers simultaneous completion with acknowledge or load, over-acknowledge clamping, immediate re-assertion after a partial acknowledge, and an irregular tick pattern.

// File: rtl/cmpl_coal_pkg.sv
// Package: shared defaults and the timer action type for the completion
// interrupt coalescing counter. Assumes nothing beyond IEEE 1800-2017.
package cmpl_coal_pkg;
    localparam int DEF_CNT_W       = 20;
    localparam int DEF_TWAIT_W     = 16;
    localparam int DEF_NWAIT_W     = 20;
    localparam int DEF_TSCALE_LOG2 = 10;

    // What the hold-off timer does on the next edge.
    typedef enum logic [1:0] {
        TMR_CLEAR = 2'd0,
        TMR_HOLD  = 2'd1,
        TMR_STEP  = 2'd2
    } tmr_act_e;
endpackage

// File: rtl/ccoal_count.sv
// Module: pending-result counter. Applies a direct load, or else the net
// effect of a one-step increment and an acknowledge subtraction. The
// result is clamped to the range [0, all-ones].
// Assumes: single clock, synchronous active-low reset.
module ccoal_count #(
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             inc,
    input  logic             sub_en,
    input  logic [CNT_W-1:0] sub_val,
    output logic [CNT_W-1:0] cnt_q
);
    localparam int EXT_W = CNT_W + 1;

    logic [EXT_W-1:0] sum_ext;
    logic [EXT_W-1:0] sub_ext;
    logic [EXT_W-1:0] diff_ext;
    logic [CNT_W-1:0] cnt_nxt;

    // Net change with clamping at both ends; a load takes priority.
    always_comb begin
        sum_ext  = {1'b0, cnt_q} + EXT_W'(inc);
        sub_ext  = sub_en ? {1'b0, sub_val} : '0;
        diff_ext = sum_ext - sub_ext;
        if (load)
            cnt_nxt = load_val;
        else if (sub_ext >= sum_ext)
            cnt_nxt = '0;
        else if (diff_ext[CNT_W])
            cnt_nxt = '1;
        else
            cnt_nxt = diff_ext[CNT_W-1:0];
    end

    // Count register.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_nxt;
    end
endmodule

// File: rtl/ccoal_timer.sv
// Module: saturating hold-off timer. Clears on restart or while nothing is
// pending, and steps on tick otherwise.
// Assumes: `pending` reflects the registered count.
module ccoal_timer
    import cmpl_coal_pkg::*;
#(
    parameter int TMR_W = 26
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             pending,
    input  logic             tick,
    output logic [TMR_W-1:0] tmr_q
);
    tmr_act_e act;

    // Choose the timer action for the coming edge.
    always_comb begin
        if (restart || !pending)
            act = TMR_CLEAR;
        else if (tick && (tmr_q != '1))
            act = TMR_STEP;
        else
            act = TMR_HOLD;
    end

    // Timer register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            unique case (act)
                TMR_CLEAR: tmr_q <= '0;
                TMR_STEP:  tmr_q <= tmr_q + 1'b1;
                default:   tmr_q <= tmr_q;
            endcase
        end
    end
endmodule

// File: rtl/ccoal_decide.sv
// Module: interrupt decision. Combines the count threshold (zero acts as
// one) and the scaled time threshold (zero disables it), then gates the
// result with the enable.
// Assumes: all inputs are registered state; the output is a level.
module ccoal_decide #(
    parameter int CNT_W       = 20,
    parameter int TWAIT_W     = 16,
    parameter int NWAIT_W     = 20,
    parameter int TSCALE_LOG2 = 10,
    parameter int TMR_W       = TWAIT_W + TSCALE_LOG2
) (
    input  logic [CNT_W-1:0]   cnt,
    input  logic [TMR_W-1:0]   tmr,
    input  logic [TWAIT_W-1:0] twait,
    input  logic [NWAIT_W-1:0] nwait,
    input  logic               ena,
    output logic               irq
);
    localparam int CMP_W = (CNT_W > NWAIT_W) ? CNT_W : NWAIT_W;

    logic [TMR_W-1:0]   thr;
    logic [NWAIT_W-1:0] nwait_eff;
    logic               time_hit;
    logic               cnt_hit;

    // Scaled time threshold; the scale may be 1 (no shift).
    generate
        if (TSCALE_LOG2 == 0) begin : g_noscale
            assign thr = TMR_W'(twait);
        end else begin : g_scale
            assign thr = {twait, {TSCALE_LOG2{1'b0}}};
        end
    endgenerate

    // Evaluate both conditions and gate with enable and nonzero count.
    always_comb begin
        nwait_eff = (nwait == '0) ? NWAIT_W'(1) : nwait;
        time_hit  = (twait != '0) && (tmr >= thr);
        cnt_hit   = CMP_W'(cnt) >= CMP_W'(nwait_eff);
        irq       = ena && (cnt != '0) && (time_hit || cnt_hit);
    end
endmodule

// File: rtl/cmpl_irq_coalesce.sv
// Module: per-queue completion interrupt coalescing counter (top).
// Holds the programmed wait values and the write-1-to-set enable, and ties
// together the counter, the hold-off timer and the decision logic.
// Assumes: register writes arrive as single-cycle strobes with data.
module cmpl_irq_coalesce
    import cmpl_coal_pkg::*;
#(
    parameter int CNT_W       = DEF_CNT_W,
    parameter int TWAIT_W     = DEF_TWAIT_W,
    parameter int NWAIT_W     = DEF_NWAIT_W,
    parameter int TSCALE_LOG2 = DEF_TSCALE_LOG2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               cmpl_vld,
    input  logic               cmpl_notify,
    input  logic               ack_we,
    input  logic [CNT_W-1:0]   ack_val,
    input  logic               cnt_we,
    input  logic [CNT_W-1:0]   cnt_val,
    input  logic               twait_we,
    input  logic [TWAIT_W-1:0] twait_val,
    input  logic               nwait_we,
    input  logic [NWAIT_W-1:0] nwait_val,
    input  logic               ena_we,
    input  logic               ena_bit,
    output logic [CNT_W-1:0]   cnt_rd,
    output logic               irq
);
    localparam int TMR_W = TWAIT_W + TSCALE_LOG2;

    logic [TWAIT_W-1:0] twait_q;
    logic [NWAIT_W-1:0] nwait_q;
    logic               ena_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [TMR_W-1:0]   tmr_q;

    // Programmed wait values and the sticky enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            twait_q <= '0;
            nwait_q <= '0;
            ena_q   <= 1'b0;
        end else begin
            if (twait_we)          twait_q <= twait_val;
            if (nwait_we)          nwait_q <= nwait_val;
            if (ena_we && ena_bit) ena_q   <= 1'b1;
        end
    end

    ccoal_count #(.CNT_W(CNT_W)) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_we),
        .load_val (cnt_val),
        .inc      (cmpl_vld && cmpl_notify),
        .sub_en   (ack_we),
        .sub_val  (ack_val),
        .cnt_q    (cnt_q)
    );

    ccoal_timer #(.TMR_W(TMR_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (ack_we || cnt_we),
        .pending (cnt_q != '0),
        .tick    (tick),
        .tmr_q   (tmr_q)
    );

    ccoal_decide #(
        .CNT_W       (CNT_W),
        .TWAIT_W     (TWAIT_W),
        .NWAIT_W     (NWAIT_W),
        .TSCALE_LOG2 (TSCALE_LOG2),
        .TMR_W       (TMR_W)
    ) u_decide (
        .cnt   (cnt_q),
        .tmr   (tmr_q),
        .twait (twait_q),
        .nwait (nwait_q),
        .ena   (ena_q),
        .irq   (irq)
    );

    assign cnt_rd = cnt_q;
endmodule

// File: rtl/ccoal_checker.sv
// Module: assertion checker for cmpl_irq_coalesce, attached by bind.
// Assumes: tmr, ena and nwait are the top's internal registers.
module ccoal_checker #(
    parameter int CNT_W   = 20,
    parameter int NWAIT_W = 20,
    parameter int TMR_W   = 26
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cmpl_vld,
    input logic               cmpl_notify,
    input logic               ack_we,
    input logic [CNT_W-1:0]   ack_val,
    input logic               cnt_we,
    input logic [CNT_W-1:0]   cnt_val,
    input logic [CNT_W-1:0]   cnt_rd,
    input logic               irq,
    input logic               ena,
    input logic [TMR_W-1:0]   tmr,
    input logic [NWAIT_W-1:0] nwait
);
    localparam int CMP_W = (CNT_W > NWAIT_W) ? CNT_W : NWAIT_W;

    // R1: a lone notifying completion below the ceiling adds one.
    a_r1_increment: assert property (@(posedge clk) disable iff (!rst_n)
        (cmpl_vld && cmpl_notify && !ack_we && !cnt_we && cnt_rd != '1)
        |=> cnt_rd == $past(cnt_rd) + 1'b1);

    // R1: no notification, no writes: count unchanged.
    a_r1_ignore: assert property (@(posedge clk) disable iff (!rst_n)
        (!(cmpl_vld && cmpl_notify) && !ack_we && !cnt_we) |=> $stable(cnt_rd));

    // R2: over-acknowledge clamps to zero.
    a_r2_clamp: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_we && !cnt_we && !(cmpl_vld && cmpl_notify) && ack_val >= cnt_rd)
        |=> cnt_rd == '0);

    // R3: direct load wins.
    a_r3_load: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_we |=> cnt_rd == $past(cnt_val));

    // R4: nothing pending means no request, and the timer is zero next cycle.
    a_r4_zero_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_rd == '0) |-> !irq);
    a_r4_timer_held: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_rd == '0) |=> tmr == '0);

    // R5: a saturated timer stays saturated while results remain pending.
    a_r5_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr == '1 && cnt_rd != '0 && !ack_we && !cnt_we) |=> tmr == '1);

    // R8: acknowledge or load restarts the timer.
    a_r8_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_we || cnt_we) |=> tmr == '0);

    // R7: enabled and count at threshold means request.
    a_r7_count_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (ena && cnt_rd != '0 &&
         CMP_W'(cnt_rd) >= CMP_W'((nwait == '0) ? NWAIT_W'(1) : nwait)) |-> irq);

    // R9: enable clear means no request.
    a_r9_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !ena |-> !irq);
endmodule

bind cmpl_irq_coalesce ccoal_checker #(
    .CNT_W   (CNT_W),
    .NWAIT_W (NWAIT_W),
    .TMR_W   (TWAIT_W + TSCALE_LOG2)
) u_ccoal_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmpl_vld    (cmpl_vld),
    .cmpl_notify (cmpl_notify),
    .ack_we      (ack_we),
    .ack_val     (ack_val),
    .cnt_we      (cnt_we),
    .cnt_val     (cnt_val),
    .cnt_rd      (cnt_rd),
    .irq         (irq),
    .ena         (ena_q),
    .tmr         (tmr_q),
    .nwait       (nwait_q)
);

// File: tb/test_cmpl_irq_coalesce.sv
module test_cmpl_irq_coalesce;
    localparam int CNT_W = 6;
    localparam int TWAIT_W = 4;
    localparam int NWAIT_W = 6;
    localparam int TSCALE_LOG2 = 2;
    localparam int CMAX = (1 << CNT_W) - 1;
    localparam int TMAX = (1 << (TWAIT_W + TSCALE_LOG2)) - 1;
    localparam int SCALE = 1 << TSCALE_LOG2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic cmpl_vld = 1'b0, cmpl_notify = 1'b0;
    logic ack_we = 1'b0;
    logic [CNT_W-1:0] ack_val = '0;
    logic cnt_we = 1'b0;
    logic [CNT_W-1:0] cnt_val = '0;
    logic twait_we = 1'b0;
    logic [TWAIT_W-1:0] twait_val = '0;
    logic nwait_we = 1'b0;
    logic [NWAIT_W-1:0] nwait_val = '0;
    logic ena_we = 1'b0, ena_bit = 1'b0;
    logic [CNT_W-1:0] cnt_rd;
    logic irq;

    int checks = 0, errors = 0;
    int m_cnt = 0, m_tmr = 0, m_tw = 0, m_nw = 0, m_ena = 0;
    string cur_req = "R11";
    bit finished = 1'b0;

    always #5 clk = ~clk;

    cmpl_irq_coalesce #(
        .CNT_W(CNT_W), .TWAIT_W(TWAIT_W), .NWAIT_W(NWAIT_W), .TSCALE_LOG2(TSCALE_LOG2)
    ) i_cmpl_irq_coalesce (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .cmpl_vld(cmpl_vld), .cmpl_notify(cmpl_notify),
        .ack_we(ack_we), .ack_val(ack_val),
        .cnt_we(cnt_we), .cnt_val(cnt_val),
        .twait_we(twait_we), .twait_val(twait_val),
        .nwait_we(nwait_we), .nwait_val(nwait_val),
        .ena_we(ena_we), .ena_bit(ena_bit),
        .cnt_rd(cnt_rd), .irq(irq)
    );

    // Expected request level from the model state (R12).
    function automatic bit exp_irq();
        int nw_eff;
        bit t_hit, c_hit;
        nw_eff = (m_nw == 0) ? 1 : m_nw;
        t_hit = (m_tw != 0) && (m_tmr >= m_tw * SCALE);
        c_hit = m_cnt >= nw_eff;
        return (m_ena != 0) && (m_cnt != 0) && (t_hit || c_hit);
    endfunction

    task automatic compare();
        checks++;
        if (int'(cnt_rd) != m_cnt) begin
            errors++;
            $display("FAIL %s count actual=%0d expected=%0d at %0t", cur_req, cnt_rd, m_cnt, $time);
        end
        checks++;
        if (irq != exp_irq()) begin
            errors++;
            $display("FAIL %s irq actual=%0b expected=%0b at %0t", cur_req, irq, exp_irq(), $time);
        end
    endtask

    // One clock: update the model from the inputs seen at the edge, then compare.
    task automatic step();
        int t, old_cnt;
        @(posedge clk);
        old_cnt = m_cnt;
        if (ack_we || cnt_we)        m_tmr = 0;
        else if (old_cnt == 0)       m_tmr = 0;
        else if (tick && m_tmr < TMAX) m_tmr = m_tmr + 1;
        if (cnt_we) m_cnt = int'(cnt_val);
        else begin
            t = old_cnt + ((cmpl_vld && cmpl_notify) ? 1 : 0) - (ack_we ? int'(ack_val) : 0);
            if (t < 0) t = 0;
            if (t > CMAX) t = CMAX;
            m_cnt = t;
        end
        if (twait_we) m_tw = int'(twait_val);
        if (nwait_we) m_nw = int'(nwait_val);
        if (ena_we && ena_bit) m_ena = 1;
        @(negedge clk);
        compare();
        cmpl_vld = 0; cmpl_notify = 0; ack_we = 0; cnt_we = 0;
        twait_we = 0; nwait_we = 0; ena_we = 0;
    endtask

    task automatic done_pulse(bit nt);
        cmpl_vld = 1; cmpl_notify = nt; step();
    endtask
    task automatic do_ack(int v);
        ack_we = 1; ack_val = CNT_W'(v); step();
    endtask
    task automatic do_load(int v);
        cnt_we = 1; cnt_val = CNT_W'(v); step();
    endtask
    task automatic set_time(int v);
        twait_we = 1; twait_val = TWAIT_W'(v); step();
    endtask
    task automatic set_num(int v);
        nwait_we = 1; nwait_val = NWAIT_W'(v); step();
    endtask
    task automatic ena_write(bit b);
        ena_we = 1; ena_bit = b; step();
    endtask
    task automatic idle(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R11: reset state.
        cur_req = "R11"; compare(); idle(2);

        // R9: enable clear suppresses the request while counting continues.
        cur_req = "R9";
        done_pulse(1);          // count 1, threshold 0 acts as 1, but disabled
        ena_write(0);           // no effect
        idle(2);
        ena_write(1);           // irq rises
        idle(1);

        // R1: notifying versus silent completions.
        cur_req = "R1";
        set_num(10);
        done_pulse(0); done_pulse(0);
        cmpl_vld = 0; cmpl_notify = 1; step();
        for (int i = 0; i < 5; i++) done_pulse(1);

        // R7: count threshold reached, and zero threshold acting as one.
        cur_req = "R7";
        for (int i = 0; i < 5; i++) done_pulse(1);   // count reaches 11
        set_num(0);
        idle(2);

        // R2: partial ack, ack with completion, over-ack clamp.
        cur_req = "R2";
        set_num(10);
        do_ack(3);
        cmpl_vld = 1; cmpl_notify = 1; ack_we = 1; ack_val = 2; step();
        do_ack(50);
        idle(2);

        // R4: timer held at zero while nothing is pending.
        cur_req = "R4";
        tick = 1;
        set_time(2); set_num(63);
        idle(12);
        done_pulse(1);
        idle(12);

        // R8: ack restarts timer; count condition rechecked at once.
        cur_req = "R8";
        do_ack(0);
        idle(10);
        set_num(1);
        do_load(5);
        do_ack(1);
        idle(2);

        // R6: time value zero disables the time trigger; irregular tick.
        cur_req = "R6";
        set_num(63); set_time(0);
        do_load(3);
        for (int i = 0; i < 40; i++) begin
            tick = (i % 3) != 0;
            step();
        end
        tick = 1;
        set_time(1);
        idle(8);

        // R5: saturating timer with the largest time threshold.
        cur_req = "R5";
        set_time(15);
        do_load(2);
        idle(80);

        // R10: increment at the ceiling.
        cur_req = "R10";
        do_load(CMAX);
        done_pulse(1);
        done_pulse(1);

        // R3: load wins over completion and ack in the same cycle.
        cur_req = "R3";
        cmpl_vld = 1; cmpl_notify = 1; ack_we = 1; ack_val = 4;
        cnt_we = 1; cnt_val = 7; step();
        idle(4);

        // R12: level holds while the condition holds.
        cur_req = "R12";
        set_num(7);
        idle(3);
        do_ack(7);
        idle(2);

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule